// File: doc/BRIEF.md
# Front-end strip latch and serializer

This block runs one detector plane's readout board. It takes 32 discriminated strip hits, 8 group-OR signals and a calibration input, and stretches every hit to a fixed width. From the stretched group signals it forms four coincidence flags: any one group, or 2, 3 or 4 cyclically adjacent groups, where group 7 is adjacent to group 0. On a trigger strobe it captures a 48-bit event word. That word is shifted out bit-serially when the shared event chain selects this board's slot.

The same chain wires also drive a monitor path. When the chain is in monitor mode, step pulses addressed to the board first enable it and then advance a channel pointer over 40 sources. The selected source drives the monitor output, so an external counter can measure its rate. Every chain step is a single-cycle strobe that is synchronous to the block clock.

Top module: `fe_plane_ctrl`

## Requirements
- R1: During reset and right after it, the fold flags are 0, the monitor output is 0 and the capture register is empty, so an addressed board in event mode drives 0 on ser_out.
- R2: A hit seen high on one clock edge keeps its stretched level high for exactly STRETCH_CYC cycles after that edge. A new hit restarts the window.
- R3: When trig is seen while no word is pending, the word {board_id[5:0], fold[3:0], monitor channel[5:0], stretched strips[31:0]} is captured, bit 47 first in the list. The fold and channel values are those before that edge.
- R4: A trig seen while a captured word still has bits left to shift is ignored, and the held word stays unchanged until all 48 bits have gone out.
- R5: In event mode (ev_mode=1) with ch_addr equal to slot_addr, ser_out shows the current MSB of the word. Each ev_step moves the next bit up, so the bits leave MSB first. With any other address, or in monitor mode, ser_out equals ser_in.
- R6: fold[0] is the OR of the 8 stretched groups, registered one cycle.
- R7: fold[k-1] for k=2,3,4 is high when some k cyclically consecutive groups (indices i..i+k-1 mod 8) are all high, registered one cycle.
- R8: In monitor mode, an addressed mon_step first sets the enable and keeps channel 0. Each later addressed step advances the channel, wrapping from 39 to 0. A mon_step with another address drops the enable. ev_step has no effect in monitor mode, and mon_step has no effect in event mode.
- R9: mon_rst, which takes priority over a step, clears the channel to 0 and drops the enable, forcing mon_out to 0.
- R10: Monitor channels map as follows: 0–31 are stretched strips 0–31, 32–38 are stretched groups 0–6, and 39 is the raw cal_in. mon_out is 0 when not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| slot_addr | input | 4 | Static chain slot of this board |
| board_id | input | 6 | Static identifier placed in the event word |
| strip_hit | input | 32 | Discriminated strip hits |
| grp_hit | input | 8 | Group-OR hit signals |
| cal_in | input | 1 | Calibration source for monitoring |
| trig | input | 1 | Final trigger strobe |
| ch_addr | input | 4 | Chain address in use |
| ev_mode | input | 1 | 1 selects event mode, 0 monitor mode |
| ev_step | input | 1 | Event-chain shift strobe |
| ser_in | input | 1 | Serial data from the upstream board |
| ser_out | output | 1 | Serial data toward the back end |
| mon_step | input | 1 | Monitor-chain step strobe |
| mon_rst | input | 1 | Monitor selector clear |
| mon_out | output | 1 | Selected monitor source |
| fold | output | 4 | Coincidence flags, bit k-1 for k-fold |

## Verification
The stretch counters load on the edge where a hit is seen, and the fold flags follow one edge later. A group pulse driven before edge E0 therefore appears on fold only after E1. The captured word takes the values held before the trig edge. ser_out and mon_out are combinational selects of registered state, so a step edge changes them in the cycle that follows it. The bench drives inputs 1 ns after each rising edge. A behavioural model advances on the same edge, and all outputs are compared against it at the falling edge. Directed checks gather all 48 serial bits and count the stretched-high cycles against these offsets.

// File: rtl/fe_plane_pkg.sv
package fe_plane_pkg;
  localparam int ADDR_W  = 4;
  localparam int ID_W    = 6;
  localparam int NFOLD   = 4;
  localparam int CH_W    = 6;
  localparam int NSTRIP  = 32;
  localparam int NGRP    = 8;
  localparam int NSRC    = NSTRIP + (NGRP - 1) + 1;
  localparam int WORD_W  = ID_W + NFOLD + CH_W + NSTRIP;
endpackage

// File: rtl/fe_hit_stretch.sv
module fe_hit_stretch #(
  parameter int LANES = 8,
  parameter int HOLD  = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] held
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      if (raw[g])             cnt_d = LOAD;
      else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign held[g] = (cnt_q != '0);

    // R2
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      raw[g] |=> held[g]);
  end
endmodule

// File: rtl/fe_fold_coinc.sv
module fe_fold_coinc #(
  parameter int NGRP  = 8,
  parameter int NFOLD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NGRP-1:0]  grp,
  output logic [NFOLD-1:0] fold
);
  logic [NFOLD-1:0] fold_d, fold_q;

  always_comb begin
    for (int k = 1; k <= NFOLD; k++) begin
      logic acc;
      acc = 1'b0;
      for (int i = 0; i < NGRP; i++) begin
        logic run;
        run = 1'b1;
        for (int j = 0; j < k; j++) run = run & grp[(i + j) % NGRP];
        acc = acc | run;
      end
      fold_d[k-1] = acc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fold_q <= '0;
    else        fold_q <= fold_d;
  end

  assign fold = fold_q;

  // R6
  fold_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp) |=> fold_q[0]);

  for (genvar k = 1; k < NFOLD; k++) begin : g_nest
    // R7
    fold_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fold_q[k] |-> fold_q[k-1]);
  end
endmodule

// File: rtl/fe_event_shift.sv
module fe_event_shift #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_req,
  input  logic [W-1:0] word_in,
  input  logic         shift_req,
  output logic         head,
  output logic         pending
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [W-1:0]     sh_q, sh_d;
  logic [CNT_W-1:0] left_q, left_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    if (load_req && left_q == '0) begin
      sh_d   = word_in;
      left_d = FULL;
    end else if (shift_req && left_q != '0) begin
      sh_d   = {sh_q[W-2:0], 1'b0};
      left_d = left_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  assign head    = sh_q[W-1];
  assign pending = (left_q != '0);

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !shift_req) |=> $stable(sh_q));

  // R5
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && shift_req) |=> (sh_q[W-1] == $past(sh_q[W-2])));
endmodule

// File: rtl/fe_mon_select.sv
module fe_mon_select #(
  parameter int NSRC = 40,
  parameter int CH_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step_hit,
  input  logic            step_miss,
  input  logic [NSRC-1:0] src,
  output logic [CH_W-1:0] ch,
  output logic            mon_out
);
  localparam int PAD = 1 << CH_W;
  localparam logic [CH_W-1:0] LAST = CH_W'(NSRC - 1);

  logic [CH_W-1:0] ch_q, ch_d;
  logic            en_q, en_d;
  logic [PAD-1:0]  src_pad;

  always_comb begin
    ch_d = ch_q;
    en_d = en_q;
    if (clr) begin
      ch_d = '0;
      en_d = 1'b0;
    end else if (step_hit) begin
      if (!en_q)             en_d = 1'b1;
      else if (ch_q == LAST) ch_d = '0;
      else                   ch_d = ch_q + CH_W'(1);
    end else if (step_miss) begin
      en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q <= '0;
      en_q <= 1'b0;
    end else begin
      ch_q <= ch_d;
      en_q <= en_d;
    end
  end

  assign src_pad = {{(PAD - NSRC){1'b0}}, src};
  assign ch      = ch_q;
  assign mon_out = en_q & src_pad[ch_q];

  // R8
  ch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_q <= LAST);

  // R8
  mon_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_hit && !en_q && !clr) |=> (en_q && $stable(ch_q)));

  // R9
  mon_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!en_q && ch_q == '0 && !mon_out));
endmodule

// File: rtl/fe_plane_ctrl.sv
module fe_plane_ctrl
  import fe_plane_pkg::*;
#(
  parameter int STRETCH_CYC = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic [ID_W-1:0]   board_id,
  input  logic [NSTRIP-1:0] strip_hit,
  input  logic [NGRP-1:0]   grp_hit,
  input  logic              cal_in,
  input  logic              trig,
  input  logic [ADDR_W-1:0] ch_addr,
  input  logic              ev_mode,
  input  logic              ev_step,
  input  logic              ser_in,
  output logic              ser_out,
  input  logic              mon_step,
  input  logic              mon_rst,
  output logic              mon_out,
  output logic [NFOLD-1:0]  fold
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NSTRIP-1:0] strip_held;
  logic [NGRP-1:0]   grp_held;
  logic [CH_W-1:0]   mon_ch;
  logic [WORD_W-1:0] ev_word;
  logic [NSRC-1:0]   mon_src;
  logic              addr_hit, ev_shift, mon_hit, mon_miss, head, pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign addr_hit = (ch_addr == slot_addr);
  assign ev_shift = ev_mode & ev_step & addr_hit;
  assign mon_hit  = ~ev_mode & mon_step & addr_hit;
  assign mon_miss = ~ev_mode & mon_step & ~addr_hit;

  fe_hit_stretch #(.LANES(NSTRIP), .HOLD(STRETCH_CYC)) u_strip_str (
    .clk(clk), .rst_n(rst_int_n), .raw(strip_hit), .held(strip_held));

  fe_hit_stretch #(.LANES(NGRP), .HOLD(STRETCH_CYC)) u_grp_str (
    .clk(clk), .rst_n(rst_int_n), .raw(grp_hit), .held(grp_held));

  fe_fold_coinc #(.NGRP(NGRP), .NFOLD(NFOLD)) u_fold (
    .clk(clk), .rst_n(rst_int_n), .grp(grp_held), .fold(fold));

  assign ev_word = {board_id, fold, mon_ch, strip_held};

  fe_event_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .load_req(trig), .word_in(ev_word),
    .shift_req(ev_shift), .head(head), .pending(pending));

  assign mon_src = {cal_in, grp_held[NGRP-2:0], strip_held};

  fe_mon_select #(.NSRC(NSRC), .CH_W(CH_W)) u_mon (
    .clk(clk), .rst_n(rst_int_n), .clr(mon_rst), .step_hit(mon_hit),
    .step_miss(mon_miss), .src(mon_src), .ch(mon_ch), .mon_out(mon_out));

  assign ser_out = (ev_mode && addr_hit) ? head : ser_in;

  // R4
  trig_ignore_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pending && trig && !ev_shift) |=> pending);
endmodule

// File: tb/fe_plane_ctrl_bench.sv
module fe_plane_ctrl_bench;
  localparam int HOLD = 8;
  localparam logic [3:0] SLOT = 4'd5;
  localparam logic [5:0] BID  = 6'h2B;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [31:0] strip_hit;
  logic [7:0]  grp_hit;
  logic        cal_in, trig, ev_mode, ev_step, ser_in, mon_step, mon_rst;
  logic [3:0]  ch_addr;
  logic        ser_out, mon_out;
  logic [3:0]  fold;

  fe_plane_ctrl #(.STRETCH_CYC(HOLD)) u_fe_plane_ctrl (
    .clk(clk), .rst_n(rst_n), .slot_addr(SLOT), .board_id(BID),
    .strip_hit(strip_hit), .grp_hit(grp_hit), .cal_in(cal_in), .trig(trig),
    .ch_addr(ch_addr), .ev_mode(ev_mode), .ev_step(ev_step), .ser_in(ser_in),
    .ser_out(ser_out), .mon_step(mon_step), .mon_rst(mon_rst),
    .mon_out(mon_out), .fold(fold));

  int n_chk = 0;
  int n_fail = 0;
  bit armed = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference
  int          scnt[32];
  int          gcnt[8];
  logic [47:0] m_word;
  int          m_left, m_ch;
  bit          m_en;
  logic [3:0]  m_fold;

  function automatic logic [3:0] fold_ref(logic [7:0] g);
    logic [3:0] r = '0;
    for (int k = 1; k <= 4; k++)
      for (int i = 0; i < 8; i++) begin
        bit all = 1;
        for (int j = 0; j < k; j++) if (!g[(i + j) % 8]) all = 0;
        if (all) r[k-1] = 1'b1;
      end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 32; s++) scnt[s] = 0;
      for (int s = 0; s < 8; s++) gcnt[s] = 0;
      m_word = '0; m_left = 0; m_ch = 0; m_en = 0; m_fold = '0;
    end else begin
      logic [31:0] sh;
      logic [7:0]  gh;
      logic [3:0]  nf;
      for (int s = 0; s < 32; s++) sh[s] = scnt[s] > 0;
      for (int s = 0; s < 8; s++) gh[s] = gcnt[s] > 0;
      nf = fold_ref(gh);
      if (trig && m_left == 0) begin
        m_word = {BID, m_fold, 6'(m_ch), sh};
        m_left = 48;
      end else if (ev_mode && ev_step && ch_addr == SLOT && m_left > 0) begin
        m_word = {m_word[46:0], 1'b0};
        m_left--;
      end
      if (mon_rst) begin
        m_en = 0; m_ch = 0;
      end else if (!ev_mode && mon_step) begin
        if (ch_addr == SLOT) begin
          if (!m_en) m_en = 1;
          else m_ch = (m_ch == 39) ? 0 : m_ch + 1;
        end else m_en = 0;
      end
      for (int s = 0; s < 32; s++)
        scnt[s] = strip_hit[s] ? HOLD : (scnt[s] > 0 ? scnt[s] - 1 : 0);
      for (int s = 0; s < 8; s++)
        gcnt[s] = grp_hit[s] ? HOLD : (gcnt[s] > 0 ? gcnt[s] - 1 : 0);
      m_fold = nf;
    end
  end

  function automatic logic mon_exp();
    if (!m_en) return 1'b0;
    if (m_ch < 32) return scnt[m_ch] > 0;
    if (m_ch < 39) return gcnt[m_ch - 32] > 0;
    return cal_in;
  endfunction

  always @(negedge clk) begin
    if (armed) begin
      chk("R6/R7 fold", 64'(fold), 64'(m_fold));
      chk("R5 ser_out", 64'(ser_out),
          64'((ev_mode && ch_addr == SLOT) ? m_word[47] : ser_in));
      chk("R8/R10 mon_out", 64'(mon_out), 64'(mon_exp()));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic ev_pulse();
    ev_step = 1; tick(); ev_step = 0; tick();
  endtask

  task automatic mon_pulse(int n);
    for (int i = 0; i < n; i++) begin
      mon_step = 1; tick(); mon_step = 0; tick();
    end
  endtask

  task automatic strip_pulse(int s);
    strip_hit[s] = 1'b1; tick(); strip_hit[s] = 1'b0;
  endtask

  task automatic run_tests();
    logic [47:0] got, expw;
    int hi;
    // R1 during and after reset
    ev_mode = 1; ch_addr = SLOT;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 fold", 64'(fold), 64'h0);
    chk("R1 mon_out", 64'(mon_out), 64'h0);
    chk("R1 ser_out", 64'(ser_out), 64'h0);
    tick(); rst_n = 1;
    repeat (5) tick();
    armed = 1;
    @(negedge clk);
    chk("R1 ser_out after reset", 64'(ser_out), 64'h0);
    tick();

    // R3 capture with wraparound 2-fold (groups 7 and 0)
    strip_hit = 32'hA5C3_0F81; grp_hit = 8'h81; tick();
    strip_hit = '0; grp_hit = '0; tick();
    trig = 1; tick(); trig = 0;
    expw = {BID, 4'b0011, 6'd0, 32'hA5C3_0F81};
    repeat (HOLD + 4) tick();
    // R4 second trigger while pending is ignored
    strip_hit = 32'h0000_FFFF; tick(); strip_hit = '0;
    trig = 1; tick(); trig = 0; tick();
    for (int k = 0; k < 48; k++) begin
      @(negedge clk); got[47 - k] = ser_out; tick();
      ev_pulse();
    end
    chk("R3/R4/R5 word high", 64'(got[47:32]), 64'(expw[47:32]));
    chk("R3/R4/R5 word low", 64'(got[31:0]), 64'(expw[31:0]));
    // R4 after readout, capture works again
    strip_hit = 32'h8000_0001; tick(); strip_hit = '0;
    trig = 1; tick(); trig = 0;
    @(negedge clk);
    chk("R4 recapture msb", 64'(ser_out), 64'(BID[5]));
    tick();

    // R5 pass-through when another slot is addressed
    ch_addr = SLOT ^ 4'd3;
    for (int i = 0; i < 4; i++) begin
      ser_in = i[0]; tick(); @(negedge clk);
      chk("R5 passthrough", 64'(ser_out), 64'(ser_in));
      tick();
    end
    ser_in = 0;
    ch_addr = SLOT;
    for (int k = 0; k < 48; k++) ev_pulse();

    // R6 R7 fold patterns
    begin
      logic [7:0] pats[6] = '{8'h01, 8'h81, 8'hC1, 8'hE1, 8'h05, 8'h18};
      logic [3:0] exps[6] = '{4'b0001, 4'b0011, 4'b0111, 4'b1111, 4'b0001, 4'b0011};
      for (int p = 0; p < 6; p++) begin
        grp_hit = pats[p]; tick(); grp_hit = '0;
        @(posedge clk); @(negedge clk);
        chk("R6/R7 fold pattern", 64'(fold), 64'(exps[p]));
        repeat (HOLD + 2) tick();
      end
    end

    // R8 monitor selection
    ev_mode = 0; ch_addr = SLOT;
    mon_rst = 1; tick(); mon_rst = 0; tick();
    mon_pulse(1);
    strip_pulse(0); @(negedge clk);
    chk("R8 enable keeps ch0", 64'(mon_out), 64'h1);
    // ev_step ignored in monitor mode
    ev_step = 1; tick(); ev_step = 0;
    repeat (HOLD + 2) tick();
    mon_pulse(5);
    // R2 stretch width on channel 5
    strip_pulse(5);
    hi = 0;
    for (int i = 0; i < HOLD + 4; i++) begin
      @(negedge clk); if (mon_out) hi++; tick();
    end
    chk("R2 stretch width", 64'(hi), 64'(HOLD));
    mon_pulse(27);
    grp_hit[0] = 1; tick(); grp_hit[0] = 0; @(negedge clk);
    chk("R10 ch32 group0", 64'(mon_out), 64'h1);
    repeat (HOLD + 2) tick();
    mon_pulse(7);
    cal_in = 1; tick(); @(negedge clk);
    chk("R10 ch39 cal", 64'(mon_out), 64'h1);
    tick(); cal_in = 0;
    mon_pulse(1);
    strip_pulse(0); @(negedge clk);
    chk("R8 wrap to ch0", 64'(mon_out), 64'h1);
    repeat (HOLD + 2) tick();
    ch_addr = SLOT ^ 4'd1; mon_pulse(1); ch_addr = SLOT;
    strip_pulse(0); @(negedge clk);
    chk("R8 other address disables", 64'(mon_out), 64'h0);
    repeat (HOLD + 2) tick();
    mon_pulse(4);
    // R8 mon_step ignored in event mode
    ev_mode = 1; mon_step = 1; tick(); mon_step = 0; ev_mode = 0; tick();
    strip_pulse(3); @(negedge clk);
    chk("R8 ch3 kept", 64'(mon_out), 64'h1);
    // R9 clear wins over step
    mon_rst = 1; mon_step = 1; tick(); mon_rst = 0; mon_step = 0;
    @(negedge clk);
    chk("R9 clear", 64'(mon_out), 64'h0);
    repeat (HOLD + 2) tick();
  endtask

  initial begin
    rst_n = 0; strip_hit = '0; grp_hit = '0; cal_in = 0; trig = 0;
    ch_addr = '0; ev_mode = 0; ev_step = 0; ser_in = 0; mon_step = 0;
    mon_rst = 0;
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    armed = 0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule